// File: doc/BRIEF.md
# PCI Interrupt Swizzle and Router

This block folds the interrupt pins of many PCI agents onto four shared interrupt request lines and sends each of those lines to one of sixteen inputs of a legacy interrupt controller. An agent reports a change on one of its pins by pulsing a strobe. With the strobe it gives its device/function number and the new level of the pin. The block turns the pin and the agent's slot into a shared-line index by a slot rotation, then stores the new level in that line's level register.

Four byte-wide routing registers pick the controller input for each shared line. A routing byte of sixteen or more leaves its line unconnected. Each controller input is the OR of every held shared-line level whose routing register points at that input. The output vector is built combinationally from the held levels and the routing bytes. A level therefore moves to a new input as soon as its routing register changes. The routing bytes can be read back through a combinational read port.

Top module: `irq_swizzle_router`

## Requirements
- R1: A strobed pin maps to shared line (pin + slot + 3) mod 4, where pin encodes INTA#..INTD# as 0..3 and slot is bits [7:3] of the device/function number.
- R2: On a strobe, the selected shared line's held level takes the strobed level at the clock edge. It keeps that value until another strobe selects the same line.
- R3: Routing registers for shared lines 0, 1, 2 and 3 sit at offsets 0x60, 0x61, 0x62 and 0x63. A write at any other offset changes no routing register.
- R4: A routing byte of 16 (0x10) or more disconnects its shared line, so that line drives no controller input.
- R5: Controller input n is the OR of the held levels of all shared lines whose routing byte equals n.
- R6: Reset (rst_n low, asynchronous) sets all routing bytes to 0x80 and all held levels to 0, so ctl_irq reads 0.
- R7: ctl_irq follows the routing registers with no added register stage. After a routing write takes effect at a clock edge, an asserted level appears on the new input in that same cycle and is gone from the old input.
- R8: cfg_rdata returns the routing byte for cfg_rd_addr 0x60..0x63 and 0x00 for any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Pin level-change strobe |
| req_devfn | input | 8 | Device/function number of the requesting agent |
| req_pin | input | 2 | Interrupt pin, 0..3 for INTA#..INTD# |
| req_level | input | 1 | New pin level |
| cfg_wr_en | input | 1 | Routing register write enable |
| cfg_wr_addr | input | 8 | Write offset |
| cfg_wdata | input | 8 | Write data |
| cfg_rd_addr | input | 8 | Read offset |
| cfg_rdata | output | 8 | Read data |
| ctl_irq | output | 16 | Interrupt controller request levels |

## Verification
The stimulus covers slot 0, where the rotation's minus one wraps to line 3, and slot 31 with pin 3. A design that subtracted without wrapping, or that ignored the slot, would light the wrong input. Two lines share one input and are released one at a time; a design that let the last writer win instead of ORing would drop the input early. Routing bytes 0x0F, 0x10 and 0x80 are checked at the boundary of the disable rule, together with writes just outside the register window.

// File: rtl/irq_swizzle_router.sv
module irq_swizzle_router #(
  parameter int          NUM_LINES   = 16,
  parameter logic [7:0]  ROUTE_BASE  = 8'h60,
  parameter logic [7:0]  ROUTE_RESET = 8'h80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_devfn,
  input  logic [1:0]  req_pin,
  input  logic        req_level,
  input  logic        cfg_wr_en,
  input  logic [7:0]  cfg_wr_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic [7:0]  cfg_rd_addr,
  output logic [7:0]  cfg_rdata,
  output logic [15:0] ctl_irq
);
  localparam int NPIRQ = 4;
  localparam int LW    = $clog2(NUM_LINES);

  logic [7:0]       route_q [NPIRQ];
  logic [NPIRQ-1:0] pirq_q;
  logic [1:0]       sw_idx;
  logic [7:0]       wr_off, rd_off;
  logic             wr_hit;

  assign sw_idx = req_pin + req_devfn[4:3] + 2'd3;
  assign wr_off = cfg_wr_addr - ROUTE_BASE;
  assign rd_off = cfg_rd_addr - ROUTE_BASE;
  assign wr_hit = cfg_wr_en && (wr_off < 8'd4);
  assign cfg_rdata = (rd_off < 8'd4) ? route_q[rd_off[1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pirq_q <= '0;
    end else if (req_valid) begin
      pirq_q[sw_idx] <= req_level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIRQ; i++) route_q[i] <= ROUTE_RESET;
    end else if (wr_hit) begin
      route_q[wr_off[1:0]] <= cfg_wdata;
    end
  end

  always_comb begin
    ctl_irq = '0;
    for (int i = 0; i < NPIRQ; i++) begin
      if (pirq_q[i] && ({24'd0, route_q[i]} < NUM_LINES))
        ctl_irq[route_q[i][LW-1:0]] = 1'b1;
    end
  end

  p_strobe_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> pirq_q[$past(sw_idx)] == $past(req_level));

  p_route_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> route_q[$past(wr_off[1:0])] == $past(cfg_wdata));

  p_irq_needs_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_irq) |-> (|pirq_q));

  p_irq_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ctl_irq) <= $countones(pirq_q));

  p_all_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (route_q[0][7:4] != 0 && route_q[1][7:4] != 0 &&
     route_q[2][7:4] != 0 && route_q[3][7:4] != 0) |-> ctl_irq == '0);

  p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_addr == ROUTE_BASE) |-> cfg_rdata == route_q[0]);
endmodule

// File: tb/irq_swizzle_router_tb.sv
module irq_swizzle_router_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_level = 0, cfg_wr_en = 0;
  logic [7:0] req_devfn = 0, cfg_wr_addr = 0, cfg_wdata = 0, cfg_rd_addr = 0;
  logic [1:0] req_pin = 0;
  logic [7:0] cfg_rdata;
  logic [15:0] ctl_irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  irq_swizzle_router dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_devfn(req_devfn),
    .req_pin(req_pin), .req_level(req_level), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_addr(cfg_wr_addr), .cfg_wdata(cfg_wdata), .cfg_rd_addr(cfg_rd_addr),
    .cfg_rdata(cfg_rdata), .ctl_irq(ctl_irq));

  // {devfn, pin, level, expected ctl_irq}; routes: line0->3, line1->5, line2->9, line3->5
  localparam logic [26:0] VEC [12] = '{
    {8'h08, 2'd0, 1'b1, 16'h0008},
    {8'h10, 2'd0, 1'b1, 16'h0028},
    {8'h20, 2'd1, 1'b0, 16'h0020},
    {8'h00, 2'd0, 1'b1, 16'h0020},
    {8'h10, 2'd0, 1'b0, 16'h0020},
    {8'h19, 2'd2, 1'b1, 16'h0028},
    {8'h0F, 2'd2, 1'b1, 16'h0228},
    {8'hF8, 2'd3, 1'b1, 16'h0228},
    {8'h00, 2'd0, 1'b0, 16'h0228},
    {8'hF8, 2'd3, 1'b0, 16'h0208},
    {8'h40, 2'd1, 1'b0, 16'h0200},
    {8'h38, 2'd0, 1'b0, 16'h0000}
  };

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic strobe(logic [7:0] devfn, logic [1:0] pin, logic lvl);
    @(negedge clk);
    req_valid = 1; req_devfn = devfn; req_pin = pin; req_level = lvl;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
    cfg_rd_addr = a;
    #1;
    chk(req, {8'h00, cfg_rdata}, {8'h00, exp});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R6 reset state
    repeat (2) @(negedge clk);
    chk("R6 irq in reset", ctl_irq, 16'h0000);
    rst_n = 1;
    @(negedge clk);
    chk("R6 irq after reset", ctl_irq, 16'h0000);
    for (int i = 0; i < 4; i++) rd_chk("R6 route reset", 8'h60 + 8'(i), 8'h80);

    // R3 route programming, R8 readback
    wr(8'h60, 8'd3); wr(8'h61, 8'd5); wr(8'h62, 8'd9); wr(8'h63, 8'd5);
    rd_chk("R8 read 0x60", 8'h60, 8'd3);
    rd_chk("R8 read 0x62", 8'h62, 8'd9);
    rd_chk("R8 read outside", 8'h64, 8'h00);

    // R1 R2 R5 vector walk
    for (int v = 0; v < 12; v++) begin
      strobe(VEC[v][26:19], VEC[v][18:17], VEC[v][16]);
      chk("R1/R2/R5 vector", ctl_irq, VEC[v][15:0]);
    end

    // R2 level holds without strobes
    strobe(8'h08, 2'd0, 1'b1);
    repeat (5) @(negedge clk);
    chk("R2 level held", ctl_irq, 16'h0008);

    // R7 reroute moves the level
    wr(8'h60, 8'd12);
    chk("R7 moved to 12", ctl_irq, 16'h1000);
    // R4 disable boundary
    wr(8'h60, 8'h10);
    chk("R4 0x10 disabled", ctl_irq, 16'h0000);
    wr(8'h60, 8'h0F);
    chk("R4 0x0F routed", ctl_irq, 16'h8000);
    wr(8'h60, 8'h80);
    chk("R4 0x80 disabled", ctl_irq, 16'h0000);
    wr(8'h60, 8'h00);
    chk("R4 0x00 routed", ctl_irq, 16'h0001);

    // R3 writes outside the window are ignored
    wr(8'h5F, 8'h07); wr(8'h64, 8'h07);
    rd_chk("R3 0x63 untouched", 8'h63, 8'd5);
    rd_chk("R3 0x60 untouched", 8'h60, 8'h00);
    chk("R3 irq untouched", ctl_irq, 16'h0001);

    // R5 all four lines on one input, released one by one
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i), 8'd7);
    strobe(8'h10, 2'd0, 1'b1); strobe(8'h18, 2'd0, 1'b1); strobe(8'h00, 2'd0, 1'b1);
    chk("R5 all merged", ctl_irq, 16'h0080);
    strobe(8'h08, 2'd0, 1'b0); strobe(8'h10, 2'd0, 1'b0); strobe(8'h18, 2'd0, 1'b0);
    chk("R5 one left", ctl_irq, 16'h0080);
    strobe(8'h00, 2'd0, 1'b0);
    chk("R5 all released", ctl_irq, 16'h0000);

    // R6 reset again clears levels and routes
    strobe(8'h08, 2'd0, 1'b1);
    @(negedge clk); rst_n = 0; #1;
    chk("R6 async reset", ctl_irq, 16'h0000);
    rd_chk("R6 route after reset", 8'h61, 8'h80);
    @(negedge clk); rst_n = 1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule